// File: doc/BRIEF.md
# Parallel Move Conflict Checker

This block sits beside the instruction decoder of a digital signal processor whose instructions can pair an arithmetic or logical operation with a data move. It compares the register written by the operation with the register written by the move. When both land in the same accumulator, it raises an illegal-instruction flag in the same cycle. The accumulator can be named whole or through one of its three slices, and any of these counts as the same accumulator. Two operations may read the same register, and the source of the move is never looked at for conflicts.

The block also fits the moved word to the register that receives it. A 24-bit word going into a 16-bit register keeps its low 16 bits. A 16-bit word going into a 24-bit register gets zeros in its top 8 bits. An 8-bit extension slice keeps the low 8 bits. A whole 56-bit accumulator takes the word in its middle slice, with the top slice sign-extended and the low slice cleared. The register write port (enable, register code and 56-bit data) is registered and appears one clock after the move is presented. It is suppressed when the instruction is illegal, when no move is issued, or when the move targets memory.

Top module: `pmc_move_check`

Register codes (4 bits): 0 = R16_0, 1 = R16_1, 14 = R16_2 (16-bit); 2 = R24_0, 3 = R24_1, 12 = R24_2, 13 = R24_3 (24-bit); 4 = A0, 5 = A1, 6 = A2, 7 = A whole; 8 = B0, 9 = B1, 10 = B2, 11 = B whole; 15 = memory or immediate word (a 24-bit source; as a destination it means a store, and as the operation's destination it means none). The accumulator layout is slice 2 in bits 55:48, slice 1 in bits 47:24 and slice 0 in bits 23:0.

## Requirements
- R1: With mv_valid_i high, illegal_o is 1 in the same cycle when alu_dst_i is in 4..7 and mv_dst_i is in 4..7, and also when both are in 8..11.
- R2: illegal_o is 0 when mv_valid_i is low, when mv_dst_i is not an accumulator code (0..3, 12..15), or when the two codes name different accumulators.
- R3: The value of mv_src_i never affects illegal_o. This holds when the source names the same register, or the same accumulator, as alu_dst_i.
- R4: One clock after the inputs are presented, wr_en_o equals mv_valid_i AND NOT illegal_o AND (mv_dst_i != 15), and wr_dst_o equals that mv_dst_i.
- R5: For a 16-bit destination (codes 0, 1, 14), wr_data_o holds the low 16 bits of the source value and zero above.
- R6: A 16-bit source (codes 0, 1, 14) is taken as the low 16 bits of mv_data_i. Written to a 24-bit register or slice (2, 3, 12, 13, 4, 5, 8, 9), it gives wr_data_o[23:16] = 0.
- R7: An extension-slice destination (6, 10) takes the low 8 bits of the source value, with zero above. An 8-bit source (6, 10) is taken as the low 8 bits of mv_data_i.
- R8: A whole-accumulator destination (7, 11) gets wr_data_o = {8 copies of source bit 23, 24-bit source value, 24 zeros}.
- R9: Source codes 15, 7, 11 and the 24-bit codes pass all 24 bits of mv_data_i, and a 24-bit destination gets them in wr_data_o[23:0] with zero above.
- R10: While rst is high at a clock edge, wr_en_o, wr_dst_o and wr_data_o become 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_dst_i | input | 4 | Destination register code of the arithmetic/logic operation |
| mv_src_i | input | 4 | Source register code of the move (15 = memory or immediate) |
| mv_dst_i | input | 4 | Destination register code of the move (15 = memory store) |
| mv_valid_i | input | 1 | A move is issued with this instruction |
| mv_data_i | input | 24 | Word being moved |
| illegal_o | output | 1 | Combinational write-conflict flag |
| wr_en_o | output | 1 | Registered register-write enable for the move |
| wr_dst_o | output | 4 | Registered destination code of the write |
| wr_data_o | output | 56 | Registered width-adapted write data |

## Verification
Two cases are hard to reach from the ports. In the first, the move reads the very accumulator slice that the operation writes while writing somewhere else: it must stay legal even though the codes match closely. The second is a conflict reached through a slice code rather than the whole accumulator. The bench reaches both by sweeping every pair of operation and move destination with the move flag both low and high. In each step it rotates the source through all sixteen codes, including the operation's own destination, and it uses random data so that sign bits and upper bits are set. A reset is also asserted while a legal move is pending, to show that the write port clears.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    RC_R16_0 = 4'd0,
    RC_R16_1 = 4'd1,
    RC_R24_0 = 4'd2,
    RC_R24_1 = 4'd3,
    RC_A0    = 4'd4,
    RC_A1    = 4'd5,
    RC_A2    = 4'd6,
    RC_AW    = 4'd7,
    RC_B0    = 4'd8,
    RC_B1    = 4'd9,
    RC_B2    = 4'd10,
    RC_BW    = 4'd11,
    RC_R24_2 = 4'd12,
    RC_R24_3 = 4'd13,
    RC_R16_2 = 4'd14,
    RC_MEM   = 4'd15
  } reg_code_e;

  typedef enum logic [1:0] {
    WC_EXT  = 2'd0,
    WC_NAR  = 2'd1,
    WC_WORD = 2'd2,
    WC_ACC  = 2'd3
  } wclass_e;

  typedef struct packed {
    logic    is_acc;
    logic    acc_sel;
    logic    is_mem;
    wclass_e wclass;
  } reg_info_t;

endpackage

// File: rtl/pmc_reg_decode.sv
module pmc_reg_decode
  import pmc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output reg_info_t         info_o
);

  always_comb begin
    info_o.is_acc  = 1'b0;
    info_o.acc_sel = 1'b0;
    info_o.is_mem  = 1'b0;
    info_o.wclass  = WC_WORD;
    unique case (reg_code_e'(code_i))
      RC_R16_0, RC_R16_1, RC_R16_2: info_o.wclass = WC_NAR;
      RC_R24_0, RC_R24_1, RC_R24_2, RC_R24_3: info_o.wclass = WC_WORD;
      RC_A0, RC_A1: begin
        info_o.is_acc = 1'b1;
        info_o.wclass = WC_WORD;
      end
      RC_A2: begin
        info_o.is_acc = 1'b1;
        info_o.wclass = WC_EXT;
      end
      RC_AW: begin
        info_o.is_acc = 1'b1;
        info_o.wclass = WC_ACC;
      end
      RC_B0, RC_B1: begin
        info_o.is_acc  = 1'b1;
        info_o.acc_sel = 1'b1;
        info_o.wclass  = WC_WORD;
      end
      RC_B2: begin
        info_o.is_acc  = 1'b1;
        info_o.acc_sel = 1'b1;
        info_o.wclass  = WC_EXT;
      end
      RC_BW: begin
        info_o.is_acc  = 1'b1;
        info_o.acc_sel = 1'b1;
        info_o.wclass  = WC_ACC;
      end
      default: begin
        info_o.is_mem = 1'b1;
        info_o.wclass = WC_WORD;
      end
    endcase
  end

endmodule

// File: rtl/pmc_alias_check.sv
module pmc_alias_check
  import pmc_pkg::*;
#(
  parameter int NUM_ACC = 2
) (
  input  logic      valid_i,
  input  reg_info_t alu_i,
  input  reg_info_t dst_i,
  output logic      conflict_o
);

  logic [NUM_ACC-1:0] hit;

  generate
    for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
      logic alu_on_k;
      logic dst_on_k;
      assign alu_on_k = alu_i.is_acc && (int'(alu_i.acc_sel) == k);
      assign dst_on_k = dst_i.is_acc && (int'(dst_i.acc_sel) == k);
      assign hit[k]   = alu_on_k && dst_on_k;
    end
  endgenerate

  assign conflict_o = valid_i && (|hit);

endmodule

// File: rtl/pmc_width_adapt.sv
module pmc_width_adapt
  import pmc_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16,
  parameter int EXT_W    = 8,
  localparam int ACC_W   = EXT_W + 2 * DATA_W
) (
  input  wclass_e           src_wc_i,
  input  wclass_e           dst_wc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ACC_W-1:0]  data_o
);

  logic [DATA_W-1:0] src_val;

  always_comb begin
    src_val = '0;
    unique case (src_wc_i)
      WC_NAR:  src_val[NARROW_W-1:0] = data_i[NARROW_W-1:0];
      WC_EXT:  src_val[EXT_W-1:0]    = data_i[EXT_W-1:0];
      default: src_val               = data_i;
    endcase
  end

  always_comb begin
    data_o = '0;
    unique case (dst_wc_i)
      WC_NAR:  data_o[NARROW_W-1:0] = src_val[NARROW_W-1:0];
      WC_EXT:  data_o[EXT_W-1:0]    = src_val[EXT_W-1:0];
      WC_ACC:  data_o = {{EXT_W{src_val[DATA_W-1]}}, src_val, {DATA_W{1'b0}}};
      default: data_o[DATA_W-1:0]   = src_val;
    endcase
  end

endmodule

// File: rtl/pmc_move_check.sv
module pmc_move_check
  import pmc_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16,
  parameter int EXT_W    = 8,
  parameter int NUM_ACC  = 2,
  localparam int ACC_W   = EXT_W + 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        alu_dst_i,
  input  logic [3:0]        mv_src_i,
  input  logic [3:0]        mv_dst_i,
  input  logic              mv_valid_i,
  input  logic [DATA_W-1:0] mv_data_i,
  output logic              illegal_o,
  output logic              wr_en_o,
  output logic [3:0]        wr_dst_o,
  output logic [ACC_W-1:0]  wr_data_o
);

  localparam int N_DEC = 3;
  localparam int I_ALU = 0;
  localparam int I_SRC = 1;
  localparam int I_DST = 2;

  logic [N_DEC-1:0][CODE_W-1:0] codes;
  reg_info_t                    info [N_DEC];
  logic                         conflict;
  logic [ACC_W-1:0]             adapted;
  logic                         wen_d;

  assign codes[I_ALU] = alu_dst_i;
  assign codes[I_SRC] = mv_src_i;
  assign codes[I_DST] = mv_dst_i;

  generate
    for (genvar i = 0; i < N_DEC; i++) begin : g_dec
      pmc_reg_decode u_dec (
        .code_i (codes[i]),
        .info_o (info[i])
      );
    end
  endgenerate

  pmc_alias_check #(.NUM_ACC(NUM_ACC)) u_alias (
    .valid_i    (mv_valid_i),
    .alu_i      (info[I_ALU]),
    .dst_i      (info[I_DST]),
    .conflict_o (conflict)
  );

  pmc_width_adapt #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .EXT_W    (EXT_W)
  ) u_adapt (
    .src_wc_i (info[I_SRC].wclass),
    .dst_wc_i (info[I_DST].wclass),
    .data_i   (mv_data_i),
    .data_o   (adapted)
  );

  assign illegal_o = conflict;
  assign wen_d     = mv_valid_i && !conflict && !info[I_DST].is_mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o   <= 1'b0;
      wr_dst_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o   <= wen_d;
      wr_dst_o  <= mv_dst_i;
      wr_data_o <= adapted;
    end
  end

  // R1: both writes on accumulator A (codes 4..7) must conflict
  p_same_acc_a_r1: assert property (@(posedge clk) disable iff (rst)
    (mv_valid_i && alu_dst_i[3:2] == 2'b01 && mv_dst_i[3:2] == 2'b01) |-> illegal_o);

  // R1: both writes on accumulator B (codes 8..11) must conflict
  p_same_acc_b_r1: assert property (@(posedge clk) disable iff (rst)
    (mv_valid_i && alu_dst_i[3:2] == 2'b10 && mv_dst_i[3:2] == 2'b10) |-> illegal_o);

  // R2: no move, no conflict
  p_no_move_r2: assert property (@(posedge clk) disable iff (rst)
    !mv_valid_i |-> !illegal_o);

  // R4: an illegal instruction never reaches the write port
  p_illegal_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> !wr_en_o);

  // R4: a memory store never writes a register
  p_store_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (mv_dst_i == 4'd15) |=> !wr_en_o);

  // R5: 16-bit destination carries nothing above bit 15
  p_narrow_dst_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && (wr_dst_o == 4'd0 || wr_dst_o == 4'd1 || wr_dst_o == 4'd14))
      |-> (wr_data_o[ACC_W-1:NARROW_W] == '0));

  // R7: extension slice carries nothing above bit 7
  p_ext_dst_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && (wr_dst_o == 4'd6 || wr_dst_o == 4'd10))
      |-> (wr_data_o[ACC_W-1:EXT_W] == '0));

  // R8: whole accumulator write clears the low slice and sign-extends the top
  p_acc_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && (wr_dst_o == 4'd7 || wr_dst_o == 4'd11))
      |-> (wr_data_o[DATA_W-1:0] == '0 &&
           wr_data_o[ACC_W-1:2*DATA_W] == {EXT_W{wr_data_o[2*DATA_W-1]}}));

endmodule

// File: tb/sim_pmc_move_check.sv
module sim_pmc_move_check;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  alu_dst_i = '0;
  logic [3:0]  mv_src_i = '0;
  logic [3:0]  mv_dst_i = '0;
  logic        mv_valid_i = 1'b0;
  logic [23:0] mv_data_i = '0;
  logic        illegal_o;
  logic        wr_en_o;
  logic [3:0]  wr_dst_o;
  logic [55:0] wr_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pmc_move_check u0 (
    .clk        (clk),
    .rst        (rst),
    .alu_dst_i  (alu_dst_i),
    .mv_src_i   (mv_src_i),
    .mv_dst_i   (mv_dst_i),
    .mv_valid_i (mv_valid_i),
    .mv_data_i  (mv_data_i),
    .illegal_o  (illegal_o),
    .wr_en_o    (wr_en_o),
    .wr_dst_o   (wr_dst_o),
    .wr_data_o  (wr_data_o)
  );

  task automatic check(input bit ok, input string req,
                       input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 1 = accumulator A, 2 = accumulator B, 0 = other
  function automatic int grp(input int c);
    if (c >= 4 && c <= 7) return 1;
    if (c >= 8 && c <= 11) return 2;
    return 0;
  endfunction

  // width in bits: 8, 16, 24 or 56 (whole accumulator)
  function automatic int wid(input int c);
    if (c == 0 || c == 1 || c == 14) return 16;
    if (c == 6 || c == 10) return 8;
    if (c == 7 || c == 11) return 56;
    return 24;
  endfunction

  function automatic longint unsigned exp_data(input int s, input int d,
                                               input longint unsigned v);
    longint unsigned sv;
    int sw;
    int dw;
    sw = wid(s);
    dw = wid(d);
    sv = (sw == 56) ? v % (64'd1 << 24) : v % (64'd1 << sw);
    if (dw == 56) begin
      if (sv >= 64'd8388608) return (sv << 24) + 64'd255 * (64'd1 << 48);
      return sv << 24;
    end
    return sv % (64'd1 << dw);
  endfunction

  task automatic apply(input int a, input int s, input int d, input bit v,
                       input logic [23:0] data, input string tag);
    bit ill_e;
    bit wen_e;
    @(negedge clk);
    alu_dst_i  = 4'(a);
    mv_src_i   = 4'(s);
    mv_dst_i   = 4'(d);
    mv_valid_i = v;
    mv_data_i  = data;
    #1;
    ill_e = v && grp(a) != 0 && grp(a) == grp(d);
    check(illegal_o == ill_e, tag, illegal_o, ill_e);
    wen_e = v && !ill_e && d != 15;
    @(posedge clk);
    #1;
    check(wr_en_o == wen_e, "R4 wr_en", wr_en_o, wen_e);
    check(wr_dst_o == 4'(d), "R4 wr_dst", wr_dst_o, d);
    check(wr_data_o == exp_data(s, d, 64'(data)), "R5/R6/R7/R8/R9 data",
          wr_data_o, exp_data(s, d, 64'(data)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check(wr_en_o == 1'b0, "R10 reset wr_en", wr_en_o, 0);
    check(wr_data_o == '0, "R10 reset data", wr_data_o, 0);
    check(wr_dst_o == '0, "R10 reset dst", wr_dst_o, 0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 sweep with rotating source (R3)
    for (int a = 0; a < 16; a++) begin
      for (int d = 0; d < 16; d++) begin
        for (int v = 0; v < 2; v++) begin
          apply(a, (a + d + v) % 16, d, v[0], 24'($urandom),
                (grp(a) != 0 && grp(a) == grp(d)) ? "R1 illegal" : "R2 legal");
        end
      end
    end

    // R3: source equal to the operation destination, every code
    for (int a = 0; a < 16; a++) begin
      apply(a, a, 3, 1'b1, 24'($urandom), "R3 shared source");
      apply(a, a, (a + 1) % 16, 1'b1, 24'($urandom), "R3 shared source near");
    end

    // R5 R6 R7 R8 R9: every source/destination width pair, random data
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 16; d++) begin
        apply(15, s, d, 1'b1, 24'($urandom) | 24'h800000, "R2 no alu dst");
        apply(2, s, d, 1'b1, 24'($urandom) & 24'h7fffff, "R2 no alu acc");
      end
    end

    // R10: reset while a legal move is pending
    @(negedge clk);
    alu_dst_i = 4'd15; mv_src_i = 4'd15; mv_dst_i = 4'd5;
    mv_valid_i = 1'b1; mv_data_i = 24'hABCDEF;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(wr_en_o == 1'b0, "R10 reset mid-move wr_en", wr_en_o, 0);
    check(wr_data_o == '0, "R10 reset mid-move data", wr_data_o, 0);
    @(negedge clk);
    rst = 1'b0;
    mv_valid_i = 1'b0;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule